// File: doc/BRIEF.md
# Framed Maskable Interrupt Controller

This block gathers the events of a three-channel framed transceiver into a single active-low interrupt line. There are eight request sources. Six of them are per-channel frame events: three on the transmit side and three on the receive side. The other two are aggregate error events. One is for transmit errors. The other is for receive errors together with clock-recovery errors. Each of the seven raw error inputs has its own enable bit, and the enabled ones are ORed into the matching aggregate.

A source raises its request bit only when it goes from low to high. That transition is detected at the frame strobe belonging to the source. Each source keeps a one-bit sample that is refreshed whenever its strobe fires. A request is set when the strobe fires, the source is high, and the stored sample is low.

Software reaches the block through a small synchronous byte bus with the following registers:
- a mask register;
- a read-only request register;
- a write-zero-to-clear register;
- an error-enable register;
- an error-status register that clears when it is read.

The interrupt pad is modelled as an active-low level plus a drive enable, which mimics an open-drain output.

Top module: `frame_irq_ctrl`

## Requirements
- R1: After reset the mask register reads 0xFF, the error-enable register reads 0x00, the request and error-status registers read 0x00, `irq_n` is 1 and `irq_oe` is 0.
- R2: Bus reads return register contents while `rst_n` is low. Writes to the mask and error-enable registers have no effect while `rst_n` is low.
- R3: Request bit map, with the transmit events on the low bits:

  | Bit | Source |
  |-----|--------|
  | 0, 1, 2 | `tx_evt[0..2]` |
  | 3, 4, 5 | `rx_evt[0..2]` |
  | 6 | transmit error aggregate |
  | 7 | receive error aggregate |

  A bit is set only in a cycle where its strobe is high, its source is high, and the source was low at that strobe's previous firing (or no firing has happened since reset). The strobe for bits 0–5 is the channel's own frame strobe. The strobe for bit 6 is the OR of `tx_frame`, and the strobe for bit 7 is the OR of `rx_frame`. The request register is at address 0x1F.
- R4: `irq_n` is 0 exactly when some request bit is 1 and the matching bit of the mask register (address 0xEB) is 0. `irq_oe` is always the inverse of `irq_n`.
- R5: Writing to the clear register (address 0xEC) clears each request bit whose written data bit is 0. Request bits whose written data bit is 1 are left unchanged.
- R6: A request set in the same cycle as a clear write to that bit remains set.
- R7: Error-enable register (address 0x3D):
  - bits 0–2 enable `tx_err[0..2]` into the transmit aggregate;
  - bits 3–5 enable `rx_err[0..2]` into the receive aggregate;
  - bit 6 enables `dpll_err` into the receive aggregate;
  - bit 7 reads 0.

  An error input that is not enabled never sets request bit 6 or 7.
- R8: The error-status register (address 0x3C) uses the same bit layout as the enable register. Each bit is set whenever its error input is high, whether or not that input is enabled. A read returns the value held before the read and clears the register.
- R9: An error input that is high in the same cycle as an error-status read is still set in the register after that read.
- R10: Read data appears on `rdata` at the first clock edge at which `rd` is high. The clear register and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_frame | input | 3 | Per-channel transmit frame strobes |
| rx_frame | input | 3 | Per-channel receive frame strobes |
| tx_evt | input | 3 | Per-channel transmit frame event sources |
| rx_evt | input | 3 | Per-channel receive frame event sources |
| tx_err | input | 3 | Per-channel transmit error inputs |
| rx_err | input | 3 | Per-channel receive error inputs |
| dpll_err | input | 1 | Clock-recovery error input |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt level |
| irq_oe | output | 1 | Pad drive enable, high while the interrupt is asserted |

## Verification
Two pairs of events can land in the same cycle and must not lose information.

The first pair is a request edge and a clear write to that same bit. The bench provokes it by raising a receive event with its strobe in the cycle where 0x00 is written to the clear register. The request register must then read back with only that bit set.

The second pair is an error pulse and a read of the error-status register. The bench raises a receive error during the read. It expects the read to return the earlier contents and the next read to show the new bit.

Random stimulus also produces both collisions often, and a per-cycle model judges them.

// File: rtl/frame_irq_ctrl.sv
module frame_irq_ctrl #(
  parameter logic [7:0] MASK_ADDR = 8'hEB,
  parameter logic [7:0] REQ_ADDR  = 8'h1F,
  parameter logic [7:0] CLR_ADDR  = 8'hEC,
  parameter logic [7:0] STAT_ADDR = 8'h3C,
  parameter logic [7:0] EN_ADDR   = 8'h3D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] tx_frame,
  input  logic [2:0] rx_frame,
  input  logic [2:0] tx_evt,
  input  logic [2:0] rx_evt,
  input  logic [2:0] tx_err,
  input  logic [2:0] rx_err,
  input  logic       dpll_err,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  output logic       irq_n,
  output logic       irq_oe
);

  logic [7:0] mask, req, smp;
  logic [6:0] err_en, err_stat;
  logic [7:0] stb, src, set_vec, clr_vec;
  logic [6:0] err_vec;
  logic       stat_rd;

  assign err_vec = {dpll_err, rx_err, tx_err};
  assign stb     = {|rx_frame, |tx_frame, rx_frame, tx_frame};
  assign src     = {|(err_vec[6:3] & err_en[6:3]), |(err_vec[2:0] & err_en[2:0]), rx_evt, tx_evt};
  assign set_vec = stb & src & ~smp;
  assign clr_vec = (wr && addr == CLR_ADDR) ? ~wdata : 8'h00;
  assign stat_rd = rd && addr == STAT_ADDR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask     <= 8'hFF;
      err_en   <= 7'h00;
      req      <= 8'h00;
      smp      <= 8'h00;
      err_stat <= 7'h00;
    end else begin
      if (wr && addr == MASK_ADDR) mask <= wdata;
      if (wr && addr == EN_ADDR) err_en <= wdata[6:0];
      req      <= (req & ~clr_vec) | set_vec;
      smp      <= (smp & ~stb) | (src & stb);
      err_stat <= (stat_rd ? 7'h00 : err_stat) | err_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (rd) begin
      case (addr)
        MASK_ADDR: rdata <= mask;
        REQ_ADDR:  rdata <= req;
        STAT_ADDR: rdata <= {1'b0, err_stat};
        EN_ADDR:   rdata <= {1'b0, err_en};
        default:   rdata <= 8'h00;
      endcase
    end
  end

  assign irq_n  = ~|(req & ~mask);
  assign irq_oe = ~irq_n;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (mask == 8'hFF && err_en == 7'h00 && irq_n));

  // R3
  set_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((req & ~$past(req) & ~$past(stb)) == 8'h00));

  // R5
  clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CLR_ADDR) |=> ((req & ~$past(wdata) & ~$past(set_vec)) == 8'h00));

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CLR_ADDR && set_vec != 8'h00) |=> ((req & $past(set_vec)) == $past(set_vec)));

  // R9
  stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((err_stat & $past(err_vec)) == $past(err_vec)));

endmodule

// File: tb/frame_irq_ctrl_test.sv
module frame_irq_ctrl_test;
  localparam logic [7:0] A_MASK = 8'hEB, A_REQ = 8'h1F, A_CLR = 8'hEC, A_STAT = 8'h3C, A_EN = 8'h3D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] tx_frame = '0, rx_frame = '0, tx_evt = '0, rx_evt = '0, tx_err = '0, rx_err = '0;
  logic dpll_err = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic irq_n, irq_oe;

  int checks = 0, errors = 0;
  logic [7:0] m_mask = 8'hFF, m_req = '0, m_smp = '0, exp_rd;
  logic [6:0] m_en = '0, m_stat = '0;

  always #2.5 clk = ~clk;

  frame_irq_ctrl uut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] rmux(input logic [7:0] a);
    case (a)
      A_MASK:  return m_mask;
      A_REQ:   return m_req;
      A_STAT:  return {1'b0, m_stat};
      A_EN:    return {1'b0, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic cyc();
    logic [6:0] ev;
    logic [7:0] stb, src, setv, clrv;
    logic rd_chk;
    ev   = {dpll_err, rx_err, tx_err};
    stb  = {|rx_frame, |tx_frame, rx_frame, tx_frame};
    src  = {|(ev[6:3] & m_en[6:3]), |(ev[2:0] & m_en[2:0]), rx_evt, tx_evt};
    setv = stb & src & ~m_smp;
    clrv = (wr && addr == A_CLR) ? ~wdata : 8'h00;
    rd_chk = rd;
    if (rd) exp_rd = rmux(addr);
    if (!rst_n) begin
      m_mask = 8'hFF; m_en = '0; m_req = '0; m_smp = '0; m_stat = '0;
    end else begin
      if (wr && addr == A_MASK) m_mask = wdata;
      if (wr && addr == A_EN) m_en = wdata[6:0];
      m_req  = (m_req & ~clrv) | setv;
      m_smp  = (m_smp & ~stb) | (src & stb);
      m_stat = ((rd && addr == A_STAT) ? 7'h00 : m_stat) | ev;
    end
    @(posedge clk);
    @(negedge clk);
    chk({7'h0, irq_n}, {7'h0, ~|(m_req & ~m_mask)}, "R4 irq_n");
    chk({7'h0, irq_oe}, {7'h0, |(m_req & ~m_mask)}, "R4 irq_oe");
    if (rd_chk) chk(rdata, exp_rd, "R10 read data");
  endtask

  task automatic rreg(input logic [7:0] a, input logic [7:0] e, input string what);
    addr = a; rd = 1'b1;
    cyc();
    rd = 1'b0;
    chk(rdata, e, what);
  endtask

  task automatic wreg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    cyc();
    wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20531));
    cyc(); cyc();
    // R2: access while reset held
    rreg(A_MASK, 8'hFF, "R2 mask read in reset");
    wreg(A_MASK, 8'h00);
    rreg(A_MASK, 8'hFF, "R2 mask write ignored in reset");
    rst_n = 1'b1;
    cyc();
    // R1
    chk({7'h0, irq_n}, 8'h01, "R1 irq_n idle");
    chk({7'h0, irq_oe}, 8'h00, "R1 irq_oe idle");
    rreg(A_EN, 8'h00, "R1 enable cleared");
    rreg(A_REQ, 8'h00, "R1 request clear");
    rreg(A_STAT, 8'h00, "R1 status clear");
    // R3
    tx_evt = 3'b010; cyc();
    rreg(A_REQ, 8'h00, "R3 no strobe no set");
    tx_frame = 3'b010; cyc(); tx_frame = 3'b000;
    rreg(A_REQ, 8'h02, "R3 tx ch2 bit1");
    // R5
    wreg(A_CLR, 8'hFD);
    rreg(A_REQ, 8'h00, "R5 write zero clears");
    tx_frame = 3'b010; cyc(); tx_frame = 3'b000;
    rreg(A_REQ, 8'h00, "R3 held level no new edge");
    tx_evt = 3'b000; tx_frame = 3'b010; cyc();
    tx_evt = 3'b010; cyc(); tx_frame = 3'b000;
    rreg(A_REQ, 8'h02, "R3 new edge after low sample");
    rx_evt = 3'b100; rx_frame = 3'b100; cyc();
    rx_evt = 3'b001; rx_frame = 3'b010; cyc(); rx_frame = 3'b000;
    rreg(A_REQ, 8'h22, "R3 rx ch3 bit5, wrong strobe ignored");
    // R4
    chk({7'h0, irq_n}, 8'h01, "R4 all masked");
    wreg(A_MASK, 8'hDF);
    chk({7'h0, irq_n}, 8'h00, "R4 unmasked bit5 asserts");
    wreg(A_MASK, 8'hFF);
    chk({7'h0, irq_n}, 8'h01, "R4 remask deasserts");
    wreg(A_MASK, 8'hFD);
    wreg(A_CLR, 8'hFF);
    rreg(A_REQ, 8'h22, "R5 write ones keep");
    wreg(A_CLR, 8'hFD);
    rreg(A_REQ, 8'h20, "R5 selective clear");
    chk({7'h0, irq_n}, 8'h01, "R4 only masked pending");
    // R6
    rx_evt = 3'b000; rx_frame = 3'b111; cyc();
    rx_evt = 3'b001; rx_frame = 3'b001;
    addr = A_CLR; wdata = 8'h00; wr = 1'b1;
    cyc();
    wr = 1'b0; rx_frame = 3'b000;
    rreg(A_REQ, 8'h08, "R6 set wins over clear");
    // R7
    wreg(A_CLR, 8'h00);
    wreg(A_EN, 8'h01);
    tx_err = 3'b001; cyc();
    rreg(A_REQ, 8'h00, "R7 aggregate waits for strobe");
    tx_frame = 3'b100; cyc(); tx_frame = 3'b000; tx_err = 3'b000;
    rreg(A_REQ, 8'h40, "R7 tx aggregate bit6");
    rx_err = 3'b001; rx_frame = 3'b001; cyc(); rx_frame = 3'b000; rx_err = 3'b000;
    rreg(A_REQ, 8'h40, "R7 disabled rx error ignored");
    // R8
    rreg(A_STAT, 8'h09, "R8 status latches all errors");
    rreg(A_STAT, 8'h00, "R8 clear on read");
    wreg(A_EN, 8'h40);
    rreg(A_EN, 8'h40, "R7 enable readback");
    dpll_err = 1'b1; rx_frame = 3'b010; cyc(); dpll_err = 1'b0; rx_frame = 3'b000;
    rreg(A_REQ, 8'hC0, "R7 dpll into rx aggregate");
    // R9
    rx_err = 3'b100;
    rreg(A_STAT, 8'h40, "R8 read returns old value");
    rx_err = 3'b000;
    rreg(A_STAT, 8'h20, "R9 error during read kept");
    // R10
    rreg(A_CLR, 8'h00, "R10 clear reg reads zero");
    rreg(8'h55, 8'h00, "R10 unmapped reads zero");
    // random mix, checked every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      tx_frame = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      rx_frame = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      tx_evt = 3'($urandom); rx_evt = 3'($urandom);
      tx_err = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      rx_err = (($urandom % 6) == 0) ? 3'($urandom) : 3'b000;
      dpll_err = (($urandom % 10) == 0);
      rst_n = (($urandom % 500) != 0);
      pick = 3'($urandom);
      case (pick)
        3'd0: addr = A_MASK; 3'd1: addr = A_REQ; 3'd2: addr = A_CLR;
        3'd3: addr = A_STAT; 3'd4: addr = A_EN; default: addr = 8'($urandom);
      endcase
      wdata = 8'($urandom);
      wr = (($urandom % 3) == 0);
      rd = (($urandom % 2) == 0);
      cyc();
    end
    rst_n = 1'b1; wr = 1'b0; rd = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule